// File: doc/BRIEF.md
# Pipelined CORDIC Phase Extractor

This block turns a stream of signed in-phase/quadrature samples into a stream of phase angles. It runs a vectoring-mode CORDIC: a sample is first swung into the right half-plane with a half-turn angle offset, then eleven shift-and-add micro-rotations drive the quadrature term toward zero. Each of them adds or subtracts one stored arctangent constant to an angle accumulator. No multiplier or divider is used anywhere in the datapath.

A new sample may enter on every clock. A result leaves exactly 17 clocks later with its own valid strobe, so a back-to-back input stream gives a back-to-back output stream. The phase is a 9-bit two's-complement word in which -256 stands for -pi and +255 for just under +pi (one LSB is pi/256). Internally the X/Y path is 16 bits wide and the angle accumulator covers a full turn in 16 bits.

Top module: `phase_cordic_top`

## Requirements
- R1: One sample is accepted on every clock in which `in_valid` is high, and a continuous input stream of N samples yields N output results on consecutive clocks.
- R2: A synchronous reset clears every in-flight valid bit, so `out_valid` is low on the clock after reset is sampled and for 17 clocks after release when no new sample is given.
- R3: `out_valid` is high exactly 17 clocks after each clock in which `in_valid` was sampled high, and low otherwise, for any pattern of gaps.
- R4: For a sample (I,Q) with I > 0 and Q != 0, `out_phase` is within 2 LSB (modulo 512) of round(atan2(Q,I)*256/pi), with the phase in two's complement where -256 is -pi.
- R5: Samples with negative I (left half-plane) also meet the 2 LSB bound modulo 512. For (-128,0) the result is near the wrap point, within 2 LSB of -256.
- R6: The sample (0,0) gives a phase of exactly 0.
- R7: Samples on an axis other than the origin meet the same bound: (I>0,0) gives about 0, (0,Q>0) about +128 and (0,Q<0) about -128.
- R8: Data presented while `in_valid` is low produces no output strobe: `out_valid` stays low 17 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_i | input | 8 | In-phase component, signed |
| in_q | input | 8 | Quadrature component, signed |
| out_valid | output | 1 | Result strobe |
| out_phase | output | 9 | Phase, signed, pi/256 per LSB |

## Verification
A bad arctangent constant, a reversed rotation direction or a missing half-turn offset shows up as a phase error on the output 17 clocks after the sample that hits it. The sweep covers every 8-bit I/Q pair, so each such error shows on the first sample whose angle depends on the faulty stage. A damaged valid pipeline shows as a strobe one or more clocks off, or as a strobe that outlives a reset. Because the gap patterns and the mid-stream reset are followed clock by clock, this appears within one latency window.

// File: rtl/phase_cordic_pkg.sv
package phase_cordic_pkg;

   // Angle accumulator width: a full turn maps onto 2**ANG_W codes.
   localparam int ANG_W    = 16;
   localparam int MAX_ITER = 16;

   // Half a turn in accumulator units (+pi and -pi share one code).
   localparam logic signed [ANG_W-1:0] HALF_TURN = 16'sh8000;

   // atan(2**-idx) scaled so that 65536 units equal one full turn.
   function automatic logic signed [ANG_W-1:0] atan_step(input int idx);
      logic signed [ANG_W-1:0] v;
      case (idx)
         0:       v = 16'sd8192;
         1:       v = 16'sd4836;
         2:       v = 16'sd2555;
         3:       v = 16'sd1297;
         4:       v = 16'sd651;
         5:       v = 16'sd326;
         6:       v = 16'sd163;
         7:       v = 16'sd81;
         8:       v = 16'sd41;
         9:       v = 16'sd20;
         10:      v = 16'sd10;
         11:      v = 16'sd5;
         12:      v = 16'sd3;
         13:      v = 16'sd1;
         14:      v = 16'sd1;
         default: v = 16'sd0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/phase_cordic_prerot.sv
module phase_cordic_prerot
   import phase_cordic_pkg::*;
#(
   parameter int IN_W = 8,
   parameter int DW   = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    vld_i,
   input  logic signed [IN_W-1:0]  i_i,
   input  logic signed [IN_W-1:0]  q_i,
   output logic signed [DW-1:0]    x_o,
   output logic signed [DW-1:0]    y_o,
   output logic signed [ANG_W-1:0] z_o,
   output logic                    zero_o
);

   // Headroom: one bit for the CORDIC gain, one for the sign.
   localparam int SHIFT = DW - IN_W - 2;

   if (SHIFT < 0) begin : g_bad_width
      $error("phase_cordic_prerot: DW too small for IN_W");
   end

   logic signed [DW-1:0] i_ext;
   logic signed [DW-1:0] q_ext;
   logic                 left_half;

   always_comb begin
      i_ext     = {{(DW-IN_W){i_i[IN_W-1]}}, i_i} <<< SHIFT;
      q_ext     = {{(DW-IN_W){q_i[IN_W-1]}}, q_i} <<< SHIFT;
      left_half = i_i[IN_W-1];
   end

   // Left half-plane: rotate by a half turn and preload the accumulator
   // with the matching offset. +pi and -pi coincide modulo a full turn,
   // so one code serves both signs of Q.
   always_ff @(posedge clk) begin
      if (left_half) begin
         x_o <= -i_ext;
         y_o <= -q_ext;
         z_o <= HALF_TURN;
      end else begin
         x_o <= i_ext;
         y_o <= q_ext;
         z_o <= '0;
      end
      zero_o <= (i_i == '0) && (q_i == '0);
   end

   AST_PREROT_RIGHT: assert property (@(posedge clk) disable iff (rst)
      vld_i |=> !x_o[DW-1]); // R5

endmodule

// File: rtl/phase_cordic_stage.sv
module phase_cordic_stage
   import phase_cordic_pkg::*;
#(
   parameter int DW  = 16,
   parameter int IDX = 0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    vld_i,
   input  logic signed [DW-1:0]    x_i,
   input  logic signed [DW-1:0]    y_i,
   input  logic signed [ANG_W-1:0] z_i,
   input  logic                    zero_i,
   output logic signed [DW-1:0]    x_o,
   output logic signed [DW-1:0]    y_o,
   output logic signed [ANG_W-1:0] z_o,
   output logic                    zero_o
);

   localparam logic signed [ANG_W-1:0] STEP = atan_step(IDX);

   if (IDX < 0 || IDX >= MAX_ITER) begin : g_bad_idx
      $error("phase_cordic_stage: IDX out of table range");
   end

   logic signed [DW-1:0] x_sh;
   logic signed [DW-1:0] y_sh;

   always_comb begin
      x_sh = x_i >>> IDX;
      y_sh = y_i >>> IDX;
   end

   // Rotate against the sign of Y so that Y heads toward zero.
   always_ff @(posedge clk) begin
      if (!y_i[DW-1]) begin
         x_o <= x_i + y_sh;
         y_o <= y_i - x_sh;
         z_o <= z_i + STEP;
      end else begin
         x_o <= x_i - y_sh;
         y_o <= y_i + x_sh;
         z_o <= z_i - STEP;
      end
      zero_o <= zero_i;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (vld_i && !x_i[DW-1]) |=> !x_o[DW-1]); // R4

   AST_ANGLE_STEP: assert property (@(posedge clk) disable iff (rst)
      vld_i |=> ((z_o == $past(z_i) + STEP) || (z_o == $past(z_i) - STEP))); // R4

endmodule

// File: rtl/phase_cordic_outq.sv
module phase_cordic_outq
   import phase_cordic_pkg::*;
#(
   parameter int OUT_W = 9,
   parameter int PAD   = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    vld_i,
   input  logic signed [ANG_W-1:0] z_i,
   input  logic                    zero_i,
   output logic signed [OUT_W-1:0] phase_o
);

   localparam int DROP = ANG_W - OUT_W;

   if (DROP < 1) begin : g_bad_out
      $error("phase_cordic_outq: OUT_W must be below ANG_W");
   end
   if (PAD < 1) begin : g_bad_pad
      $error("phase_cordic_outq: PAD must be at least 1");
   end

   localparam logic signed [ANG_W-1:0] HALF_LSB = ANG_W'(1 << (DROP - 1));

   logic signed [ANG_W-1:0] rnd;
   logic signed [OUT_W-1:0] ph_next;
   logic signed [OUT_W-1:0] pipe [PAD];

   always_comb begin
      rnd     = z_i + HALF_LSB;
      ph_next = zero_i ? '0 : rnd[ANG_W-1 -: OUT_W];
   end

   always_ff @(posedge clk) begin
      pipe[0] <= ph_next;
   end

   if (PAD > 1) begin : g_delay
      for (genvar k = 1; k < PAD; k++) begin : g_tap
         always_ff @(posedge clk) begin
            pipe[k] <= pipe[k-1];
         end
      end
   end

   assign phase_o = pipe[PAD-1];

   AST_ZERO_PHASE: assert property (@(posedge clk) disable iff (rst)
      (vld_i && zero_i) |=> (pipe[0] == '0)); // R6

endmodule

// File: rtl/phase_cordic_top.sv
module phase_cordic_top
   import phase_cordic_pkg::*;
#(
   parameter int IN_W    = 8,
   parameter int OUT_W   = 9,
   parameter int DW      = 16,
   parameter int ITERS   = 11,
   parameter int LATENCY = 17
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_i,
   input  logic signed [IN_W-1:0]  in_q,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_phase
);

   // Input register + pre-rotation + ITERS micro-rotations + output pad.
   localparam int PAD   = LATENCY - ITERS - 2;
   localparam int Y_LIM = 1 << (DW - 4);

   if (ITERS < 1 || ITERS > MAX_ITER) begin : g_bad_iters
      $error("phase_cordic_top: ITERS outside supported range");
   end
   if (PAD < 1) begin : g_bad_latency
      $error("phase_cordic_top: LATENCY too short for ITERS");
   end
   if (DW < IN_W + 3) begin : g_bad_dw
      $error("phase_cordic_top: DW lacks headroom");
   end

   logic [LATENCY-1:0]     vld_sr;
   logic signed [IN_W-1:0] i_q;
   logic signed [IN_W-1:0] q_q;

   always_ff @(posedge clk) begin
      if (rst) vld_sr <= '0;
      else     vld_sr <= {vld_sr[LATENCY-2:0], in_valid};
   end

   always_ff @(posedge clk) begin
      i_q <= in_i;
      q_q <= in_q;
   end

   logic signed [DW-1:0]    xs [ITERS+1];
   logic signed [DW-1:0]    ys [ITERS+1];
   logic signed [ANG_W-1:0] zs [ITERS+1];
   logic                    zf [ITERS+1];

   phase_cordic_prerot #(.IN_W(IN_W), .DW(DW)) prerot_i (
      .clk    (clk),
      .rst    (rst),
      .vld_i  (vld_sr[0]),
      .i_i    (i_q),
      .q_i    (q_q),
      .x_o    (xs[0]),
      .y_o    (ys[0]),
      .z_o    (zs[0]),
      .zero_o (zf[0])
   );

   for (genvar k = 0; k < ITERS; k++) begin : g_iter
      phase_cordic_stage #(.DW(DW), .IDX(k)) stage_i (
         .clk    (clk),
         .rst    (rst),
         .vld_i  (vld_sr[k+1]),
         .x_i    (xs[k]),
         .y_i    (ys[k]),
         .z_i    (zs[k]),
         .zero_i (zf[k]),
         .x_o    (xs[k+1]),
         .y_o    (ys[k+1]),
         .z_o    (zs[k+1]),
         .zero_o (zf[k+1])
      );
   end

   phase_cordic_outq #(.OUT_W(OUT_W), .PAD(PAD)) outq_i (
      .clk     (clk),
      .rst     (rst),
      .vld_i   (vld_sr[ITERS+1]),
      .z_i     (zs[ITERS]),
      .zero_i  (zf[ITERS]),
      .phase_o (out_phase)
   );

   assign out_valid = vld_sr[LATENCY-1];

   AST_RST_CLEARS: assert property (@(posedge clk)
      $past(rst) |-> !out_valid); // R2

   AST_X_FINAL: assert property (@(posedge clk) disable iff (rst)
      vld_sr[ITERS+1] |-> !xs[ITERS][DW-1]); // R4

   AST_Y_SETTLED: assert property (@(posedge clk) disable iff (rst)
      vld_sr[ITERS+1] |-> ((ys[ITERS] < Y_LIM) && (ys[ITERS] > -Y_LIM))); // R4

endmodule

// File: tb/phase_cordic_tb.sv
`timescale 1ns/1ps
module phase_cordic_top_tb_top;

   localparam int LAT  = 17;
   localparam int HLEN = 32;
   localparam real PI  = 3.14159265358979323846;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic signed [7:0] in_i = '0;
   logic signed [7:0] in_q = '0;
   logic              out_valid;
   logic signed [8:0] out_phase;

   int checks = 0;
   int errors = 0;
   int n      = 0;
   int sweep_outs = 0;
   bit in_sweep   = 1'b0;
   bit done       = 1'b0;

   // History: kind 0 = real sample, 1 = gap garbage, 2 = cleared by reset
   bit h_v [HLEN];
   int h_i [HLEN];
   int h_q [HLEN];
   int h_k [HLEN];

   always #5 clk = ~clk;

   phase_cordic_top dut_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_i      (in_i),
      .in_q      (in_q),
      .out_valid (out_valid),
      .out_phase (out_phase)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (step %0d)", tag, act, exp, n);
      end
   endtask

   function automatic int phase_err(int act, int ii, int qq);
      real a;
      int  e;
      int  d;
      a = $atan2(real'(qq), real'(ii));
      e = int'(a * 256.0 / PI);
      d = (((act - e) % 512) + 512 + 256) % 512 - 256;
      return d;
   endfunction

   function automatic int phase_ref(int ii, int qq);
      int e;
      e = int'($atan2(real'(qq), real'(ii)) * 256.0 / PI);
      if (e > 255) e = e - 512;
      return e;
   endfunction

   // Check outputs for this step, then drive the next input.
   task automatic step(input bit v, input int ii, input int qq, input bit r, input int kind);
      int  idx;
      bit  ev;
      int  act;
      int  d;
      string tag;
      @(negedge clk);
      idx = (n - LAT) & (HLEN - 1);
      ev  = (n >= LAT) ? h_v[idx] : 1'b0;
      case ((n >= LAT) ? h_k[idx] : 2)
         1:       tag = "R8";
         2:       tag = "R2";
         default: tag = "R3";
      endcase
      check(out_valid == ev, tag, int'(out_valid), int'(ev));
      if (ev && out_valid) begin
         act = int'(out_phase);
         if (in_sweep) sweep_outs++;
         if (h_i[idx] == 0 && h_q[idx] == 0) begin
            check(act == 0, "R6", act, 0);
         end else begin
            d = phase_err(act, h_i[idx], h_q[idx]);
            if (h_i[idx] == 0 || h_q[idx] == 0)
               tag = "R7";
            else if (h_i[idx] < 0)
               tag = "R5";
            else
               tag = "R4";
            check(d <= 2 && d >= -2, tag, act, phase_ref(h_i[idx], h_q[idx]));
         end
      end
      rst      = r;
      in_valid = v;
      in_i     = 8'(ii);
      in_q     = 8'(qq);
      if (r) begin
         for (int k = 0; k < HLEN; k++) begin
            h_v[k] = 1'b0;
            h_k[k] = 2;
         end
      end
      idx      = n & (HLEN - 1);
      h_v[idx] = v && !r;
      h_i[idx] = ii;
      h_q[idx] = qq;
      h_k[idx] = r ? 2 : (v ? 0 : 1);
      n++;
   endtask

   initial begin : watchdog
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      int lfsr;
      int s;
      for (int k = 0; k < HLEN; k++) begin
         h_v[k] = 1'b0;
         h_k[k] = 2;
      end
      // Reset held, then released with idle input (R2)
      for (int k = 0; k < 4; k++) step(1'b1, 5, 5, 1'b1, 2);
      for (int k = 0; k < LAT + 2; k++) step(1'b0, 0, 0, 1'b0, 1);

      // Axis and corner points (R5, R6, R7)
      step(1'b1, 0, 0, 1'b0, 0);
      step(1'b1, 100, 0, 1'b0, 0);
      step(1'b1, 0, 100, 1'b0, 0);
      step(1'b1, 0, -100, 1'b0, 0);
      step(1'b1, -128, 0, 1'b0, 0);
      step(1'b1, -128, -128, 1'b0, 0);
      step(1'b1, 127, 127, 1'b0, 0);
      step(1'b1, 1, 1, 1'b0, 0);
      for (int k = 0; k < LAT + 2; k++) step(1'b0, 0, 0, 1'b0, 1);

      // Exhaustive back-to-back sweep (R1, R3, R4, R5, R6, R7)
      in_sweep = 1'b1;
      for (int ii = -128; ii < 128; ii++)
         for (int qq = -128; qq < 128; qq++)
            step(1'b1, ii, qq, 1'b0, 0);
      for (int k = 0; k < LAT; k++) step(1'b0, 0, 0, 1'b0, 1);
      in_sweep = 1'b0;
      check(sweep_outs == 65536, "R1", sweep_outs, 65536);

      // Irregular gaps with garbage data on idle cycles (R3, R8)
      lfsr = 32'h1ace;
      for (int k = 0; k < 400; k++) begin
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
         s = lfsr & 16'hffff;
         step(s[0], (s >> 1) % 128 - 64, (s >> 8) % 128 - 64, 1'b0, s[0] ? 0 : 1);
      end

      // Reset with samples in flight (R2)
      for (int k = 0; k < 10; k++) step(1'b1, 30 + k, -20 - k, 1'b0, 0);
      step(1'b1, 9, 9, 1'b1, 2);
      step(1'b1, 9, 9, 1'b1, 2);
      for (int k = 0; k < LAT + 2; k++) step(1'b0, 77, -77, 1'b0, 1);

      // Fresh traffic after reset
      for (int k = 0; k < 20; k++) step(1'b1, -50 + 5 * k, 40 - 3 * k, 1'b0, 0);
      for (int k = 0; k < LAT + 2; k++) step(1'b0, 0, 0, 1'b0, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule